// File: doc/BRIEF.md
# 32-bit Integer Execute Unit with Shifter and Bit Counting

This block is the purely combinational integer execute stage of a 32-bit load-store processor core. Each cycle the surrounding pipeline presents two register operands, a 16-bit immediate, a 5-bit shift amount and an operation code. The block returns a 32-bit result, a write-enable for the destination register and an overflow-trap flag. No state is held inside the block.

The operation set covers several groups:
- addition and subtraction, in forms that trap on signed overflow and in forms that never trap
- bitwise logic with register or immediate operands
- signed and unsigned less-than tests
- counting of leading ones or leading zeros
- swapping the two bytes inside each halfword
- left, logical-right and arithmetic-right shifts, and right rotates, with the amount taken either from the instruction or from a register
- placing an immediate in the upper half of the result

For the two conditional-move forms, the pipeline uses the write-enable output to decide whether the destination is written at all.

Top module: `int_exec_alu`

## Requirements
- R1: `OP_ADD`, `OP_ADDI` and `OP_SUB` return the low 32 bits of rs+rt, rs+imm or rs-rt, and raise `ovf_trap_o` exactly when the true signed result does not fit in 32 bits.
- R2: `OP_ADDU`, `OP_ADDIU` and `OP_SUBU` return the same wrapped sum or difference with `ovf_trap_o` low. No operation other than those named in R1 ever raises `ovf_trap_o`.
- R3: `OP_ADDI`, `OP_ADDIU`, `OP_SLTI` and `OP_SLTIU` sign-extend `imm_i`. `OP_ANDI`, `OP_ORI` and `OP_XORI` zero-extend it.
- R4: `OP_AND`, `OP_OR`, `OP_XOR` and `OP_NOR` apply the bitwise operation to rs and rt. NOR returns ~(rs | rt).
- R5: `OP_SLT` and `OP_SLTI` compare as two's complement. `OP_SLTU` and `OP_SLTIU` compare as unsigned magnitudes. The result is always 1 (less) or 0.
- R6: `OP_CLO` and `OP_CLZ` return the number of consecutive ones, or zeros, starting at bit 31 of rs. An all-ones operand (for CLO) or an all-zeros operand (for CLZ) gives 32.
- R7: `OP_WSBH` exchanges the two bytes of each halfword of rs: the result bits 31:24, 23:16, 15:8 and 7:0 hold rs bits 23:16, 31:24, 7:0 and 15:8.
- R8: `OP_MOVN` and `OP_MOVZ` return rs. `wr_en_o` is high for MOVN only when rt is nonzero, and for MOVZ only when rt is zero. Every other operation drives `wr_en_o` high.
- R9: `OP_SLL`, `OP_SRL`, `OP_SRA` and `OP_ROTR` shift rs by `shamt_i`. The variable forms `OP_SLLV`, `OP_SRLV`, `OP_SRAV` and `OP_ROTRV` use only rt bits 4:0 and ignore `shamt_i`.
- R10: Logical right shifts fill with zeros. Arithmetic right shifts replicate rs bit 31. Left shifts fill with zeros.
- R11: Right rotates move the bits shifted out at the bottom into the top. A rotate by 0 returns rs unchanged.
- R12: `OP_LUI` returns `imm_i` in bits 31:16 and zeros in bits 15:0, regardless of rs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand; also the variable shift amount and the move condition |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Instruction shift amount |
| op_i | input | 5 | Operation code, an `alu_pkg::op_e` value |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write-enable |
| ovf_trap_o | output | 1 | Signed overflow trap request |

## Verification
The embedded assertions assume that `op_i` always carries one of the defined `op_e` codes and that all inputs are stable, known values while they are examined. The bench only drives enumerated codes. It changes inputs on the falling clock edge and inspects the outputs one nanosecond later, when the combinational paths have settled. Operand values are picked on purpose: sign-boundary sums, all-zero and all-one words, and shift amounts whose upper rt bits are set. This makes every branch of the guarded logic execute with legal inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN    = 32;
    localparam int IMM_W   = 16;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int CNT_W   = $clog2(XLEN + 1);
    localparam int OP_W    = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU,
        OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_XOR, OP_XORI, OP_NOR,
        OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU,
        OP_CLO, OP_CLZ, OP_WSBH, OP_MOVN, OP_MOVZ,
        OP_SLL, OP_SRL, OP_SRA, OP_ROTR,
        OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV,
        OP_LUI
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT, SH_RLOG, SH_RARI, SH_ROTR
    } shift_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic            ovf;
        logic            lt_s;
        logic            lt_u;
    } addsub_res_t;

    // Exchange the two bytes inside every halfword.
    function automatic logic [XLEN-1:0] swap_half_bytes(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int h = 0; h < XLEN / 16; h++) begin
            r[h*16 +: 8]     = v[h*16 + 8 +: 8];
            r[h*16 + 8 +: 8] = v[h*16 +: 8];
        end
        return r;
    endfunction

    function automatic logic is_trap_op(input op_e op);
        return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_SUB);
    endfunction

    function automatic logic is_sub_op(input op_e op);
        return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) ||
               (op == OP_SLTU) || (op == OP_SLTI) || (op == OP_SLTIU);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o  = full[W-1:0];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
        lt_s_o = sum_o[W-1] ^ ovf_o;
        lt_u_o = ~full[W];

        // R1: carry-chain overflow agrees with a widened signed sum
        if (!sub_i) begin
            a_r1_add_overflow: assert (ovf_o ==
                (($signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i})) > $signed({2'b00, {(W-1){1'b1}}}) ||
                 ($signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i})) < $signed({2'b11, {(W-1){1'b0}}})));
        end
        // R5: borrow-based unsigned compare agrees with a magnitude compare
        if (sub_i) begin
            a_r5_unsigned_lt: assert (lt_u_o == (a_i < b_i));
        end
    end

endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count
    import alu_pkg::*;
#(
    parameter int W   = XLEN,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data_i,
    input  logic          ones_i,
    output logic [CW-1:0] count_o
);

    always_comb begin
        logic found;
        found   = 1'b0;
        count_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && (data_i[i] != ones_i)) begin
                count_o = CW'(W - 1 - i);
                found   = 1'b1;
            end
        end

        // R6: the first bit past the run has the opposite value; a full count means a uniform word
        if (int'(count_o) < W) begin
            a_r6_run_ends: assert (data_i[W - 1 - int'(count_o)] != ones_i);
        end else begin
            a_r6_full_run: assert (data_i == {W{ones_i}});
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int  W       = XLEN,
    localparam int STAGES  = $clog2(W)
) (
    input  logic [W-1:0]      data_i,
    input  logic [STAGES-1:0] amt_i,
    input  shift_kind_e       kind_i,
    output logic [W-1:0]      data_o
);

    logic [W-1:0] stg [0:STAGES];
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic         fill;

    // Left shifts reuse the right-shift network on bit-reversed data.
    always_comb begin
        rev_in = {<<{data_i}};
        fill   = (kind_i == SH_RARI) && data_i[W-1];
    end

    assign stg[0] = (kind_i == SH_LEFT) ? rev_in : data_i;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            if (kind_i == SH_ROTR) moved = {stg[i][S-1:0], stg[i][W-1:S]};
            else                   moved = {{S{fill}}, stg[i][W-1:S]};
        end
        assign stg[i+1] = amt_i[i] ? moved : stg[i];
    end

    always_comb begin
        rev_out = {<<{stg[STAGES]}};
        data_o  = (kind_i == SH_LEFT) ? rev_out : stg[STAGES];

        // R10: a logical right shift leaves the vacated top bits clear
        if (kind_i == SH_RLOG && amt_i != '0) begin
            a_r10_zero_fill: assert ((data_o >> (W - int'(amt_i))) == '0);
        end
        // R11: rotating by zero passes the operand through
        if (kind_i == SH_ROTR && amt_i == '0) begin
            a_r11_rotate_zero: assert (data_o == data_i);
        end
    end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import alu_pkg::*;
(
    input  logic [31:0] rs_i,
    input  logic [31:0] rt_i,
    input  logic [15:0] imm_i,
    input  logic [4:0]  shamt_i,
    input  logic [4:0]  op_i,
    output logic [31:0] result_o,
    output logic        wr_en_o,
    output logic        ovf_trap_o
);

    op_e               op;
    logic [XLEN-1:0]   imm_sx, imm_zx;
    logic [XLEN-1:0]   add_b, logic_b;
    addsub_res_t       ar;
    logic [CNT_W-1:0]  lead_cnt;
    shift_kind_e       sh_kind;
    logic [SHAMT_W-1:0] sh_amt;
    logic [XLEN-1:0]   sh_out;

    always_comb begin
        op     = op_e'(op_i);
        imm_sx = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        imm_zx = {{(XLEN-IMM_W){1'b0}}, imm_i};
        unique case (op)
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: add_b = imm_sx;
            default:                               add_b = rt_i;
        endcase
        unique case (op)
            OP_ANDI, OP_ORI, OP_XORI: logic_b = imm_zx;
            default:                  logic_b = rt_i;
        endcase
        unique case (op)
            OP_SRL, OP_SRLV:   sh_kind = SH_RLOG;
            OP_SRA, OP_SRAV:   sh_kind = SH_RARI;
            OP_ROTR, OP_ROTRV: sh_kind = SH_ROTR;
            default:           sh_kind = SH_LEFT;
        endcase
        unique case (op)
            OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV: sh_amt = rt_i[SHAMT_W-1:0];
            default:                             sh_amt = shamt_i;
        endcase
    end

    alu_addsub #(.W(XLEN)) u_addsub (
        .a_i    (rs_i),
        .b_i    (add_b),
        .sub_i  (is_sub_op(op)),
        .sum_o  (ar.sum),
        .ovf_o  (ar.ovf),
        .lt_s_o (ar.lt_s),
        .lt_u_o (ar.lt_u)
    );

    alu_lead_count #(.W(XLEN)) u_lead (
        .data_i  (rs_i),
        .ones_i  (op == OP_CLO),
        .count_o (lead_cnt)
    );

    alu_shifter #(.W(XLEN)) u_shift (
        .data_i (rs_i),
        .amt_i  (sh_amt),
        .kind_i (sh_kind),
        .data_o (sh_out)
    );

    always_comb begin
        wr_en_o    = 1'b1;
        ovf_trap_o = is_trap_op(op) && ar.ovf;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
            OP_ADDI, OP_ADDIU:             result_o = ar.sum;
            OP_AND, OP_ANDI:               result_o = rs_i & logic_b;
            OP_OR, OP_ORI:                 result_o = rs_i | logic_b;
            OP_XOR, OP_XORI:               result_o = rs_i ^ logic_b;
            OP_NOR:                        result_o = ~(rs_i | logic_b);
            OP_SLT, OP_SLTI:               result_o = {{(XLEN-1){1'b0}}, ar.lt_s};
            OP_SLTU, OP_SLTIU:             result_o = {{(XLEN-1){1'b0}}, ar.lt_u};
            OP_CLO, OP_CLZ:                result_o = {{(XLEN-CNT_W){1'b0}}, lead_cnt};
            OP_WSBH:                       result_o = swap_half_bytes(rs_i);
            OP_MOVN: begin
                result_o = rs_i;
                wr_en_o  = (rt_i != '0);
            end
            OP_MOVZ: begin
                result_o = rs_i;
                wr_en_o  = (rt_i == '0);
            end
            OP_SLL, OP_SRL, OP_SRA, OP_ROTR,
            OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV: result_o = sh_out;
            OP_LUI:                        result_o = {imm_i, {(XLEN-IMM_W){1'b0}}};
            default:                       result_o = '0;
        endcase

        // R2: only the trapping arithmetic forms may request a trap
        if (!is_trap_op(op)) begin
            a_r2_no_overflow: assert (!ovf_trap_o);
        end
        // R5: comparison results are boolean
        if (op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU}) begin
            a_r5_bool_result: assert (result_o[XLEN-1:1] == '0);
        end
        // R8: non-move operations always write the destination
        if (!(op inside {OP_MOVN, OP_MOVZ})) begin
            a_r8_write_always: assert (wr_en_o);
        end
        // R12: the lower half of an upper-immediate load is clear
        if (op == OP_LUI) begin
            a_r12_lui_low_clear: assert (result_o[IMM_W-1:0] == '0);
        end
    end

endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic [31:0] rs, rt;
    logic [15:0] imm;
    logic [4:0]  shamt;
    logic [4:0]  op;
    logic [31:0] result;
    logic        wr_en, ovf_trap;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    int_exec_alu u_int_exec_alu (
        .rs_i(rs), .rt_i(rt), .imm_i(imm), .shamt_i(shamt), .op_i(op),
        .result_o(result), .wr_en_o(wr_en), .ovf_trap_o(ovf_trap)
    );

    task automatic drive(input op_e o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sa);
        @(negedge clk);
        op = o; rs = a; rt = b; imm = im; shamt = sa;
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_lead(input logic [31:0] v, input logic one);
        int n = 0;
        while (n < 32 && v[31 - n] == one) n++;
        return 32'(n);
    endfunction

    task automatic t_reset_state;
        drive(OP_ADDU, 32'h0, 32'h0, 16'h0, 5'd0);
        check("R2 idle result", result, 32'h0);
        check("R2 idle trap", {31'b0, ovf_trap}, 32'h0);
        check("R8 idle wr_en", {31'b0, wr_en}, 32'h1);
    endtask

    task automatic t_add_trap;
        drive(OP_ADD, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        check("R1 add sum", result, 32'h80000000);
        check("R1 add trap", {31'b0, ovf_trap}, 32'h1);
        drive(OP_ADD, 32'hfffffffe, 32'h1, 16'h0, 5'd0);
        check("R1 add no trap", {31'b0, ovf_trap}, 32'h0);
        drive(OP_SUB, 32'h80000000, 32'h1, 16'h0, 5'd0);
        check("R1 sub diff", result, 32'h7fffffff);
        check("R1 sub trap", {31'b0, ovf_trap}, 32'h1);
        drive(OP_ADDI, 32'h80000000, 32'h0, 16'hffff, 5'd0);
        check("R1 addi sum", result, 32'h7fffffff);
        check("R1 addi trap", {31'b0, ovf_trap}, 32'h1);
    endtask

    task automatic t_add_notrap;
        drive(OP_ADDU, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        check("R2 addu sum", result, 32'h80000000);
        check("R2 addu trap", {31'b0, ovf_trap}, 32'h0);
        drive(OP_SUBU, 32'h80000000, 32'h1, 16'h0, 5'd0);
        check("R2 subu trap", {31'b0, ovf_trap}, 32'h0);
        drive(OP_ADDIU, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);
        check("R2 addiu trap", {31'b0, ovf_trap}, 32'h0);
        drive(OP_SLT, 32'h80000000, 32'h1, 16'h0, 5'd0);
        check("R2 slt trap", {31'b0, ovf_trap}, 32'h0);
    endtask

    task automatic t_immediates;
        drive(OP_ADDIU, 32'd5, 32'h0, 16'hffff, 5'd0);
        check("R3 addiu sign ext", result, 32'd4);
        drive(OP_ORI, 32'hffff0000, 32'h0, 16'h8000, 5'd0);
        check("R3 ori zero ext", result, 32'hffff8000);
        drive(OP_XORI, 32'h0, 32'h0, 16'h8001, 5'd0);
        check("R3 xori zero ext", result, 32'h00008001);
        drive(OP_ANDI, 32'hffffffff, 32'h0, 16'h8001, 5'd0);
        check("R3 andi zero ext", result, 32'h00008001);
        drive(OP_SLTIU, 32'd5, 32'h0, 16'hffff, 5'd0);
        check("R3 sltiu sign ext", result, 32'h1);
    endtask

    task automatic t_logic;
        drive(OP_AND, 32'hf0f0ff00, 32'h3c3c0ff0, 16'h0, 5'd0);
        check("R4 and", result, 32'h30300f00);
        drive(OP_OR, 32'hf0f0ff00, 32'h3c3c0ff0, 16'h0, 5'd0);
        check("R4 or", result, 32'hfcfcfff0);
        drive(OP_XOR, 32'hf0f0ff00, 32'h3c3c0ff0, 16'h0, 5'd0);
        check("R4 xor", result, 32'hccccf0f0);
        drive(OP_NOR, 32'hf0f0ff00, 32'h3c3c0ff0, 16'h0, 5'd0);
        check("R4 nor", result, 32'h0303000f);
    endtask

    task automatic t_compare;
        drive(OP_SLT, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        check("R5 slt signed", result, 32'h1);
        drive(OP_SLTU, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        check("R5 sltu unsigned", result, 32'h0);
        drive(OP_SLT, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0);
        check("R5 slt overflowing diff", result, 32'h0);
        drive(OP_SLTI, 32'h80000000, 32'h0, 16'h0000, 5'd0);
        check("R5 slti negative", result, 32'h1);
        drive(OP_SLTU, 32'd7, 32'd7, 16'h0, 5'd0);
        check("R5 sltu equal", result, 32'h0);
    endtask

    task automatic t_counts;
        logic [31:0] pats [6] = '{32'h0, 32'hffffffff, 32'h1, 32'hf0000000, 32'h00010000, 32'hfffe0000};
        foreach (pats[k]) begin
            drive(OP_CLZ, pats[k], 32'h0, 16'h0, 5'd0);
            check("R6 clz", result, ref_lead(pats[k], 1'b0));
            drive(OP_CLO, pats[k], 32'h0, 16'h0, 5'd0);
            check("R6 clo", result, ref_lead(pats[k], 1'b1));
        end
    endtask

    task automatic t_swap;
        drive(OP_WSBH, 32'h11223344, 32'h0, 16'h0, 5'd0);
        check("R7 wsbh", result, 32'h22114433);
        drive(OP_WSBH, 32'hff00a55a, 32'h0, 16'h0, 5'd0);
        check("R7 wsbh pattern", result, 32'h00ff5aa5);
    endtask

    task automatic t_moves;
        drive(OP_MOVN, 32'hdeadbeef, 32'h0, 16'h0, 5'd0);
        check("R8 movn rt zero wr_en", {31'b0, wr_en}, 32'h0);
        drive(OP_MOVN, 32'hdeadbeef, 32'h80000000, 16'h0, 5'd0);
        check("R8 movn rt nonzero wr_en", {31'b0, wr_en}, 32'h1);
        check("R8 movn data", result, 32'hdeadbeef);
        drive(OP_MOVZ, 32'h12345678, 32'h0, 16'h0, 5'd0);
        check("R8 movz rt zero wr_en", {31'b0, wr_en}, 32'h1);
        check("R8 movz data", result, 32'h12345678);
        drive(OP_MOVZ, 32'h12345678, 32'h1, 16'h0, 5'd0);
        check("R8 movz rt nonzero wr_en", {31'b0, wr_en}, 32'h0);
    endtask

    task automatic t_shifts;
        logic [31:0] v = 32'h9a3c5e71;
        for (int n = 0; n < 32; n++) begin
            drive(OP_SLL, v, 32'h0, 16'h0, 5'(n));
            check("R9 sll", result, v << n);
            drive(OP_SRL, v, 32'h0, 16'h0, 5'(n));
            check("R10 srl", result, v >> n);
            drive(OP_SRA, v, 32'h0, 16'h0, 5'(n));
            check("R10 sra", result, 32'($signed(v) >>> n));
            drive(OP_ROTRV, v, 32'hffffffe0 | 32'(n), 16'h0, 5'(31 - n));
            check("R11 rotrv", result, (v >> n) | (v << ((32 - n) % 32)));
        end
        drive(OP_SRLV, 32'h80000000, 32'h00000024, 16'h0, 5'd9);
        check("R9 srlv low rt bits", result, 32'h08000000);
        drive(OP_SRAV, 32'h80000000, 32'hffffff04, 16'h0, 5'd0);
        check("R9 srav low rt bits", result, 32'hf8000000);
        drive(OP_SLLV, 32'h1, 32'h0000003f, 16'h0, 5'd2);
        check("R9 sllv low rt bits", result, 32'h80000000);
        drive(OP_ROTR, 32'h12345678, 32'h0, 16'h0, 5'd0);
        check("R11 rotr by zero", result, 32'h12345678);
        drive(OP_ROTR, 32'h12345678, 32'h0, 16'h0, 5'd8);
        check("R11 rotr by 8", result, 32'h78123456);
    endtask

    task automatic t_lui;
        drive(OP_LUI, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd7);
        check("R12 lui", result, 32'habcd0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        op = OP_ADDU; rs = '0; rt = '0; imm = '0; shamt = '0;
        t_reset_state();
        t_add_trap();
        t_add_notrap();
        t_immediates();
        t_logic();
        t_compare();
        t_counts();
        t_swap();
        t_moves();
        t_shifts();
        t_lui();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule